// File: doc/BRIEF.md
# Correctable ECC Error Tally Bank

This block keeps running counts of correctable memory errors for a controller with two channels. Each count is 15 bits wide and carries a sticky overflow flag. The counts are packed two to a 32-bit register, and there are four registers: two for each channel. When an error event arrives tagged with a channel, DIMM and rank, the block picks one count field, adds one to it, and raises the field's overflow flag when the count wraps.

The way events map onto counts depends on how many DIMMs are fitted on the channel, which a static configuration input supplies. With three DIMMs there is one count per DIMM. With one or two DIMMs there is one count per pair of ranks on each DIMM. Software reads, clears or preloads the registers through a small indexed port. Read data appears one cycle after the request.

Top module: `ecc_err_tally`

## Requirements
- R1: After reset, every count and overflow bit of all four registers reads as 0.
- R2: Register index bit 1 selects the channel and bit 0 selects the first or second register of that channel. In each register, bits 14:0 are the lower count, bit 15 is the lower overflow, bits 30:16 are the upper count and bit 31 is the upper overflow.
- R3: When a channel's population code (2 bits per channel in `dimm_pop`, channel 0 in bits 1:0) is 3, which means three DIMMs, the mapping is as follows. DIMM 0 goes to the lower field of the channel's first register. DIMM 1 goes to the upper field of that register. DIMM 2 goes to the lower field of the second register.
- R4: With any other population code, DIMM 0 uses the first register and DIMM 1 uses the second register. Ranks 0–1 count in the lower field and ranks 2–3 count in the upper field.
- R5: Each accepted event adds exactly 1 to exactly one count.
- R6: An increment at count 0x7FFF wraps the count to 0 and sets that field's overflow bit. The overflow bit stays set through later increments until software writes it.
- R7: A write loads all 32 bits of the indexed register from `reg_wdata`.
- R8: When a write and an increment target the same register in the same cycle, the write value lands and the increment is lost. An increment to a different register in that cycle still counts.
- R9: In three-DIMM mode, the upper 16 bits of the channel's second register read as 0, even after a write of nonzero data.
- R10: An event whose DIMM has no counter changes no register. This covers DIMM 3 in three-DIMM mode, and DIMM 2 or 3 in the other modes.
- R11: A read request with `reg_we` low returns the register contents on `reg_rdata` at the next clock edge. `reg_rdata` holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_vld | input | 1 | Correctable error event strobe |
| err_ch | input | 1 | Channel of the event |
| err_dimm | input | 2 | DIMM of the event |
| err_rank | input | 2 | Rank of the event |
| dimm_pop | input | 4 | Per-channel population code (3 = three DIMMs) |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |

## Verification
Two population codes are driven at once: channel 0 runs in three-DIMM mode and channel 1 in two-DIMM mode. The same DIMM tag therefore lands in a different register or field on each channel, which exposes any confusion between the two mappings or the field halves. Preloads next to 0x7FFF separate a correct wrap-and-flag from a saturating or non-sticky count. Same-cycle write-and-event patterns on the same register and on different registers show that only the colliding increment is dropped. Events with unmapped DIMM tags, and writes to the unused field, show that nothing outside the map moves.

// File: rtl/ecc_tally_pkg.sv
package ecc_tally_pkg;
    localparam int TALLY_CNT_W = 15;
    localparam int TALLY_IDX_W = 2;
    localparam logic [1:0] POP_THREE = 2'd3;

    typedef struct packed {
        logic                   hit;
        logic [TALLY_IDX_W-1:0] reg_idx;
        logic                   hi;
    } tally_sel_t;
endpackage

// File: rtl/ecc_tally_map.sv
module ecc_tally_map
    import ecc_tally_pkg::*;
(
    input  logic       err_vld,
    input  logic       err_ch,
    input  logic [1:0] err_dimm,
    input  logic [1:0] err_rank,
    input  logic [3:0] dimm_pop,
    output tally_sel_t sel
);
    logic [1:0] pop_ch;
    logic       three;

    always_comb begin
        pop_ch = dimm_pop[{err_ch, 1'b0} +: 2];
        three  = (pop_ch == POP_THREE);
        sel    = '0;
        if (err_vld) begin
            if (three) begin
                unique case (err_dimm)
                    2'd0: sel = '{hit: 1'b1, reg_idx: {err_ch, 1'b0}, hi: 1'b0};
                    2'd1: sel = '{hit: 1'b1, reg_idx: {err_ch, 1'b0}, hi: 1'b1};
                    2'd2: sel = '{hit: 1'b1, reg_idx: {err_ch, 1'b1}, hi: 1'b0};
                    default: sel = '0;
                endcase
            end else if (!err_dimm[1]) begin
                sel = '{hit: 1'b1, reg_idx: {err_ch, err_dimm[0]}, hi: err_rank[1]};
            end
        end
    end
endmodule

// File: rtl/ecc_tally_field.sv
module ecc_tally_field #(
    parameter int CNT_W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr,
    input  logic [CNT_W:0] wdata,
    output logic [CNT_W:0] val
);
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (wr) begin
            cnt_q <= wdata[CNT_W-1:0];
            ovf_q <= wdata[CNT_W];
        end else if (inc) begin
            if (&cnt_q) begin
                cnt_q <= '0;
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign val = {ovf_q, cnt_q};
endmodule

// File: rtl/ecc_err_tally.sv
module ecc_err_tally
    import ecc_tally_pkg::*;
#(
    parameter int CNT_W       = TALLY_CNT_W,
    parameter int NUM_CH      = 2,
    parameter int REGS_PER_CH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  err_vld,
    input  logic                  err_ch,
    input  logic [1:0]            err_dimm,
    input  logic [1:0]            err_rank,
    input  logic [3:0]            dimm_pop,
    input  logic                  reg_req,
    input  logic                  reg_we,
    input  logic [1:0]            reg_idx,
    input  logic [2*CNT_W+1:0]    reg_wdata,
    output logic [2*CNT_W+1:0]    reg_rdata
);
    localparam int FIELD_W = CNT_W + 1;
    localparam int REG_W   = 2 * FIELD_W;
    localparam int NUM_REG = NUM_CH * REGS_PER_CH;

    tally_sel_t               sel;
    logic [NUM_REG*REG_W-1:0] regs_flat;
    logic [REG_W-1:0]         rd_next;
    logic                     sw_wr;
    logic                     sw_rd;

    assign sw_wr = reg_req &&  reg_we;
    assign sw_rd = reg_req && !reg_we;

    ecc_tally_map u_map (
        .err_vld  (err_vld),
        .err_ch   (err_ch),
        .err_dimm (err_dimm),
        .err_rank (err_rank),
        .dimm_pop (dimm_pop),
        .sel      (sel)
    );

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        for (genvar f = 0; f < 2; f++) begin : g_fld
            logic hit_here;
            logic wr_here;
            assign hit_here = sel.hit && (sel.reg_idx == r[1:0]) && (sel.hi == f[0]);
            assign wr_here  = sw_wr && (reg_idx == r[1:0]);
            ecc_tally_field #(.CNT_W(CNT_W)) u_fld (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (hit_here),
                .wr    (wr_here),
                .wdata (reg_wdata[f*FIELD_W +: FIELD_W]),
                .val   (regs_flat[r*REG_W + f*FIELD_W +: FIELD_W])
            );
        end
    end

    always_comb begin
        rd_next = regs_flat[reg_idx*REG_W +: REG_W];
        if (reg_idx[0] && (dimm_pop[{reg_idx[1], 1'b0} +: 2] == POP_THREE)) begin
            rd_next[REG_W-1:FIELD_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (sw_rd) begin
            reg_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/ecc_err_tally_chk.sv
module ecc_err_tally_chk #(
    parameter int FIELD_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 err_vld,
    input logic [3:0]           dimm_pop,
    input logic                 reg_req,
    input logic                 reg_we,
    input logic [1:0]           reg_idx,
    input logic [2*FIELD_W-1:0] reg_wdata,
    input logic [2*FIELD_W-1:0] reg_rdata,
    input logic [8*FIELD_W-1:0] regs_flat
);
    localparam int REG_W = 2 * FIELD_W;

    // R11: read of register 0 returns its contents one edge later
    a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && reg_idx == 2'd0) |=> (reg_rdata == $past(regs_flat[REG_W-1:0])));

    // R7: a write lands the full word
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_idx == 2'd1) |=> (regs_flat[2*REG_W-1:REG_W] == $past(reg_wdata)));

    // R6: overflow flag of register 0 lower field is sticky without a write
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_flat[FIELD_W-1] && !(reg_req && reg_we && reg_idx == 2'd0)) |=> regs_flat[FIELD_W-1]);

    // R5: nothing changes without an event or a write
    a_r5_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_vld && !(reg_req && reg_we)) |=> $stable(regs_flat));

    // R9: unused upper field reads as zero in three-DIMM mode
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && reg_idx == 2'd1 && dimm_pop[1:0] == 2'd3)
        |=> (reg_rdata[REG_W-1:FIELD_W] == '0));

    // R11: read data holds when no read is made
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && !reg_we) |=> $stable(reg_rdata));
endmodule

bind ecc_err_tally ecc_err_tally_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_vld   (err_vld),
    .dimm_pop  (dimm_pop),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .regs_flat (regs_flat)
);

// File: tb/test_ecc_err_tally.sv
module test_ecc_err_tally;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_vld = 1'b0;
    logic        err_ch = 1'b0;
    logic [1:0]  err_dimm = '0;
    logic [1:0]  err_rank = '0;
    logic [3:0]  dimm_pop = 4'b10_11;
    logic        reg_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [4];

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_err_tally i_ecc_err_tally (
        .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_ch(err_ch),
        .err_dimm(err_dimm), .err_rank(err_rank), .dimm_pop(dimm_pop),
        .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // model of the count map, from R3/R4/R10
    function automatic bit map_ev(input bit ch, input logic [1:0] d, input logic [1:0] r,
                                  output logic [1:0] idx, output bit hi);
        bit three;
        three = (dimm_pop[{ch, 1'b0} +: 2] == 2'd3);
        idx = 2'd0;
        hi  = 1'b0;
        if (three) begin
            if (d == 2'd3) return 1'b0;
            idx = {ch, (d == 2'd2)};
            hi  = (d == 2'd1);
            return 1'b1;
        end
        if (d[1]) return 1'b0;
        idx = {ch, d[0]};
        hi  = r[1];
        return 1'b1;
    endfunction

    function automatic logic [15:0] bump(input logic [15:0] f);
        if (f[14:0] == 15'h7FFF) return 16'h8000;
        return {f[15], f[14:0] + 15'd1};
    endfunction

    task automatic apply_ev(input bit ch, input logic [1:0] d, input logic [1:0] r,
                            input bit skip_reg_valid, input logic [1:0] skip_reg);
        logic [1:0] idx;
        bit hi;
        if (map_ev(ch, d, r, idx, hi) && !(skip_reg_valid && idx == skip_reg)) begin
            if (hi) mdl[idx][31:16] = bump(mdl[idx][31:16]);
            else    mdl[idx][15:0]  = bump(mdl[idx][15:0]);
        end
    endtask

    task automatic ev(input bit ch, input logic [1:0] d, input logic [1:0] r);
        @(negedge clk);
        err_vld = 1'b1; err_ch = ch; err_dimm = d; err_rank = r;
        @(negedge clk);
        err_vld = 1'b0;
        apply_ev(ch, d, r, 1'b0, 2'd0);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_idx = idx; reg_wdata = data;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
        mdl[idx] = data;
    endtask

    task automatic wr_and_ev(input logic [1:0] idx, input logic [31:0] data,
                             input bit ch, input logic [1:0] d, input logic [1:0] r);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_idx = idx; reg_wdata = data;
        err_vld = 1'b1; err_ch = ch; err_dimm = d; err_rank = r;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0; err_vld = 1'b0;
        apply_ev(ch, d, r, 1'b1, idx);
        mdl[idx] = data;
    endtask

    // driver: issues a read and pushes the expected word (R2, R9, R11)
    task automatic rd(input logic [1:0] idx, input string tag);
        exp_t item;
        item.exp = mdl[idx];
        if (idx[0] && dimm_pop[{idx[1], 1'b0} +: 2] == 2'd3) item.exp[31:16] = '0;
        item.tag = tag;
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b0; reg_idx = idx;
        q.push_back(item);
        @(negedge clk);
        reg_req = 1'b0;
    endtask

    // monitor: compares one edge after each sampled read (R11)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && reg_req && !reg_we) begin
                exp_t item;
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R11 unexpected read: actual %h expected none", reg_rdata);
                end else begin
                    item = q.pop_front();
                    if (reg_rdata !== item.exp) begin
                        errors++;
                        $display("FAIL %s: actual %h expected %h", item.tag, reg_rdata, item.exp);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R11 watchdog expired: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 4; i++) rd(i[1:0], "R1 reset zero");

        // channel 0 three-DIMM, channel 1 two-DIMM
        repeat (3) ev(1'b0, 2'd0, 2'd1);
        repeat (2) ev(1'b0, 2'd1, 2'd0);
        ev(1'b0, 2'd2, 2'd3);
        rd(2'd0, "R3 R5 three-DIMM reg0 expect 0x00020003");
        rd(2'd1, "R3 three-DIMM reg1 expect 0x00000001");
        ev(1'b0, 2'd3, 2'd0);
        rd(2'd0, "R10 dimm3 dropped reg0");
        rd(2'd1, "R10 dimm3 dropped reg1");

        ev(1'b1, 2'd0, 2'd0);
        ev(1'b1, 2'd0, 2'd1);
        ev(1'b1, 2'd0, 2'd2);
        ev(1'b1, 2'd1, 2'd3);
        ev(1'b1, 2'd2, 2'd0);
        rd(2'd2, "R4 R2 rank pairs reg2 expect 0x00010002");
        rd(2'd3, "R4 R10 dimm1 reg3 expect 0x00010000");

        wr(2'd2, 32'h7FFF_7FFE);
        ev(1'b1, 2'd0, 2'd0);
        rd(2'd2, "R7 R5 preload then inc expect 0x7FFF7FFF");
        ev(1'b1, 2'd0, 2'd1);
        ev(1'b1, 2'd0, 2'd3);
        rd(2'd2, "R6 wrap sets overflow expect 0x80008000");
        ev(1'b1, 2'd0, 2'd0);
        rd(2'd2, "R6 overflow sticky expect 0x80008001");
        wr(2'd2, 32'h0);
        rd(2'd2, "R7 software clear");

        wr_and_ev(2'd0, 32'h0000_0010, 1'b0, 2'd0, 2'd0);
        rd(2'd0, "R8 write wins same register");
        wr_and_ev(2'd3, 32'h0005_0006, 1'b0, 2'd2, 2'd0);
        rd(2'd1, "R8 other register still counts");
        rd(2'd3, "R8 R7 written register");

        wr(2'd1, 32'hFFFF_0005);
        ev(1'b0, 2'd2, 2'd0);
        rd(2'd1, "R9 unused upper field reads zero");

        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R11 reads unanswered: actual %0d expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule